// File: doc/BRIEF.md
# Shared Bus Arbiter for Multiple Processors and a Host

This block decides which of several bus masters owns one shared external bus. Up to six processor agents each raise a request line and receive a grant line; a host processor has its own request and grant pair and outranks every processor agent. Among the processor agents, a runtime input chooses one of two orders. In fixed order the lowest agent number wins. In rotating order the search starts just after the agent that last held the bus.

A master keeps the bus while it keeps requesting. It also keeps it while the lock input is high, so that a semaphore read-modify-write cannot be split. When nobody else wants the bus, the last master stays parked on it. Passing the bus from one master to a different one always inserts exactly one cycle in which no grant is driven. The block reports the current owner both as a one-hot grant and as an encoded master number with a valid flag.

Top module: `mp_bus_arbiter`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, no grant is asserted and `master_valid` is low.
- R2: At most one of `proc_grant`/`host_grant` is high in any cycle. `master_valid` is high exactly when a grant is high. `master_id` then holds the agent number (0 to N-1), or N for the host.
- R3: When no master owns the bus, a request seen at a clock edge is granted from that edge on, with no idle cycle.
- R4: An unlocked processor owner that keeps requesting keeps the bus, even when other processor agents request.
- R5: A change of owner from one master to a different one takes exactly one cycle with no grant. The new grant appears at the next edge, even if its request has dropped by then.
- R6: With `rotate_en` low, the requesting processor agent with the lowest number wins.
- R7: With `rotate_en` high, the search starts at the agent after the one that last held the bus and wraps from N-1 to 0. After reset the search starts at agent 0.
- R8: A host request takes priority over all processor requests. It ends an unlocked processor's ownership at the next edge, even if that processor is still requesting.
- R9: While `bus_lock` is high and a master owns the bus, that owner keeps the bus. This holds even if it drops its request or the host requests.
- R10: When the owner stops requesting and no other master requests, the owner keeps its grant, and no idle cycle is spent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_req | input | N_AGENTS | Bus request, one bit per processor agent |
| host_req | input | 1 | Host bus request |
| rotate_en | input | 1 | 1 = rotating order, 0 = fixed order |
| bus_lock | input | 1 | Current owner holds the bus |
| proc_grant | output | N_AGENTS | One-hot grant to processor agents |
| host_grant | output | 1 | Grant to the host |
| master_id | output | ID_W | Encoded owner, N_AGENTS means host |
| master_valid | output | 1 | A grant is currently asserted |

## Verification
All outputs are registers, so a decision made from the inputs sampled at one rising edge is visible right after that edge. A direct grant from idle or a parked keep is due one cycle after the stimulus. A change between two masters shows its empty cycle one cycle after the stimulus and the new grant two cycles after it. The bench computes the expected outputs at each rising edge from the inputs in force at that edge. It queues them, and a monitor compares them with the outputs at the following falling edge, so every result is checked in the cycle it is due.

// File: rtl/mp_bus_arb_pkg.sv
package mp_bus_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OWN  = 2'd1,
    ST_HAND = 2'd2
  } arb_state_t;
endpackage

// File: rtl/mp_arb_pick.sv
module mp_arb_pick #(
  parameter int N_AGENTS = 6,
  parameter int ID_W     = $clog2(N_AGENTS + 1)
) (
  input  logic [N_AGENTS-1:0] req,
  input  logic                rotate_en,
  input  logic [ID_W-1:0]     last_id,
  output logic                any_req,
  output logic [ID_W-1:0]     win_id
);
  int base;

  always_comb begin
    if (rotate_en) begin
      base = int'(last_id) + 1;
      if (base >= N_AGENTS) base = 0;
    end else begin
      base = 0;
    end
  end

  always_comb begin
    any_req = 1'b0;
    win_id  = '0;
    for (int i = 0; i < N_AGENTS; i++) begin
      int idx;
      idx = base + i;
      if (idx >= N_AGENTS) idx = idx - N_AGENTS;
      if (!any_req && req[idx]) begin
        any_req = 1'b1;
        win_id  = ID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/mp_arb_ctrl.sv
module mp_arb_ctrl
  import mp_bus_arb_pkg::*;
#(
  parameter int N_AGENTS = 6,
  parameter int ID_W     = $clog2(N_AGENTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_AGENTS-1:0] req,
  input  logic                host_req,
  input  logic                lock,
  input  logic                pick_any,
  input  logic [ID_W-1:0]     pick_id,
  output arb_state_t          state_q,
  output logic [ID_W-1:0]     owner_q,
  output logic [ID_W-1:0]     last_proc_q,
  output logic                nxt_own,
  output logic [ID_W-1:0]     nxt_owner
);
  localparam logic [ID_W-1:0] HOST_ID = ID_W'(N_AGENTS);

  arb_state_t      nxt_state;
  logic [ID_W-1:0] pend_q, nxt_pend, nxt_last;
  logic [N_AGENTS:0] req_all;
  logic            owner_is_host, owner_req, cand_valid;
  logic [ID_W-1:0] cand_id;

  assign req_all       = {host_req, req};
  assign owner_is_host = (owner_q == HOST_ID);
  assign owner_req     = req_all[owner_q];
  assign cand_valid    = host_req | pick_any;
  assign cand_id       = host_req ? HOST_ID : pick_id;

  always_comb begin
    nxt_state = state_q;
    nxt_owner = owner_q;
    nxt_pend  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cand_valid) begin
          nxt_state = ST_OWN;
          nxt_owner = cand_id;
        end
      end
      ST_OWN: begin
        if (lock) begin
          nxt_state = ST_OWN;
        end else if (!owner_is_host && host_req) begin
          nxt_state = ST_HAND;
          nxt_pend  = HOST_ID;
        end else if (owner_req) begin
          nxt_state = ST_OWN;
        end else if (cand_valid) begin
          nxt_state = ST_HAND;
          nxt_pend  = cand_id;
        end
      end
      ST_HAND: begin
        nxt_state = ST_OWN;
        nxt_owner = pend_q;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  assign nxt_own  = (nxt_state == ST_OWN);
  assign nxt_last = (nxt_own && nxt_owner != HOST_ID) ? nxt_owner : last_proc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      owner_q     <= '0;
      pend_q      <= '0;
      last_proc_q <= ID_W'(N_AGENTS - 1);
    end else begin
      state_q     <= nxt_state;
      owner_q     <= nxt_owner;
      pend_q      <= nxt_pend;
      last_proc_q <= nxt_last;
    end
  end
endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter
  import mp_bus_arb_pkg::*;
#(
  parameter int N_AGENTS = 6,
  localparam int ID_W    = $clog2(N_AGENTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_AGENTS-1:0] proc_req,
  input  logic                host_req,
  input  logic                rotate_en,
  input  logic                bus_lock,
  output logic [N_AGENTS-1:0] proc_grant,
  output logic                host_grant,
  output logic [ID_W-1:0]     master_id,
  output logic                master_valid
);
  localparam logic [ID_W-1:0] HOST_ID = ID_W'(N_AGENTS);

  arb_state_t      state_q;
  logic [ID_W-1:0] owner_q, last_proc_q, pick_id, nxt_owner;
  logic            pick_any, nxt_own;

  mp_arb_pick #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_pick (
    .req       (proc_req),
    .rotate_en (rotate_en),
    .last_id   (last_proc_q),
    .any_req   (pick_any),
    .win_id    (pick_id)
  );

  mp_arb_ctrl #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req         (proc_req),
    .host_req    (host_req),
    .lock        (bus_lock),
    .pick_any    (pick_any),
    .pick_id     (pick_id),
    .state_q     (state_q),
    .owner_q     (owner_q),
    .last_proc_q (last_proc_q),
    .nxt_own     (nxt_own),
    .nxt_owner   (nxt_owner)
  );

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_grant
    always_ff @(posedge clk) begin
      if (rst) proc_grant[g] <= 1'b0;
      else     proc_grant[g] <= nxt_own && (nxt_owner == ID_W'(g));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_grant <= 1'b0;
    else     host_grant <= nxt_own && (nxt_owner == HOST_ID);
  end

  assign master_id    = owner_q;
  assign master_valid = (state_q == ST_OWN);
endmodule

// File: rtl/mp_bus_arbiter_chk.sv
module mp_bus_arbiter_chk #(
  parameter int N_AGENTS = 6,
  localparam int ID_W    = $clog2(N_AGENTS + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic [N_AGENTS-1:0] proc_req,
  input logic                host_req,
  input logic                rotate_en,
  input logic                bus_lock,
  input logic [N_AGENTS-1:0] proc_grant,
  input logic                host_grant,
  input logic [ID_W-1:0]     master_id,
  input logic                master_valid
);
  localparam logic [ID_W-1:0] HOST_ID = ID_W'(N_AGENTS);

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (proc_grant == '0 && !host_grant && !master_valid));

  // R2
  p_single_grant_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({host_grant, proc_grant}));

  // R2
  p_valid_matches_r2: assert property (@(posedge clk) disable iff (rst)
    master_valid == (host_grant || (proc_grant != '0)));

  // R5: owner never changes without an empty cycle in between
  p_gap_on_change_r5: assert property (@(posedge clk) disable iff (rst)
    (master_valid && $past(master_valid)) |-> $stable(master_id));

  // R9
  p_lock_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (master_valid && bus_lock) |=> (master_valid && $stable(master_id)));

  // R8
  p_host_preempts_r8: assert property (@(posedge clk) disable iff (rst)
    (master_valid && master_id != HOST_ID && !bus_lock && host_req) |=> !master_valid);

  // R10
  p_park_r10: assert property (@(posedge clk) disable iff (rst)
    (master_valid && proc_req == '0 && !host_req) |=> (master_valid && $stable(master_id)));
endmodule

bind mp_bus_arbiter mp_bus_arbiter_chk #(.N_AGENTS(N_AGENTS)) u_chk (.*);

// File: tb/test_mp_bus_arbiter.sv
module test_mp_bus_arbiter;
  localparam int N    = 6;
  localparam int ID_W = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] proc_req = '0;
  logic host_req = 1'b0, rotate_en = 1'b0, bus_lock = 1'b0;
  logic [N-1:0] proc_grant;
  logic host_grant, master_valid;
  logic [ID_W-1:0] master_id;

  always #2 clk = ~clk;

  mp_bus_arbiter #(.N_AGENTS(N)) i_mp_bus_arbiter (
    .clk(clk), .rst(rst), .proc_req(proc_req), .host_req(host_req),
    .rotate_en(rotate_en), .bus_lock(bus_lock), .proc_grant(proc_grant),
    .host_grant(host_grant), .master_id(master_id), .master_valid(master_valid)
  );

  typedef struct { bit v; int id; string tag; } exp_t;
  exp_t q[$];
  string tag = "R1";
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model: 0 idle, 1 owning, 2 changing
  int m_st = 0, m_own = 0, m_pend = 0, m_last = N - 1;

  function automatic int pick_proc(logic [N-1:0] r, bit rot, int last);
    int first = rot ? (last + 1) % N : 0;
    for (int k = 0; k < N; k++) if (r[(first + k) % N]) return (first + k) % N;
    return -1;
  endfunction

  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      m_st = 0; m_own = 0; m_pend = 0; m_last = N - 1;
    end else begin
      int p;
      bit own_asks;
      p = pick_proc(proc_req, rotate_en, m_last);
      own_asks = (m_own == N) ? host_req : proc_req[m_own];
      if (m_st == 2) begin
        m_st = 1; m_own = m_pend;
        if (m_own < N) m_last = m_own;
      end else if (m_st == 0) begin
        if (host_req) begin m_st = 1; m_own = N; end
        else if (p >= 0) begin m_st = 1; m_own = p; m_last = p; end
      end else if (!bus_lock) begin
        if (host_req && m_own != N) begin m_st = 2; m_pend = N; end
        else if (!own_asks) begin
          if (host_req) begin m_st = 2; m_pend = N; end
          else if (p >= 0) begin m_st = 2; m_pend = p; end
        end
      end
    end
    e.v = (m_st == 1); e.id = m_own; e.tag = tag;
    q.push_back(e);
  end

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [N-1:0] eg;
      bit eh, bad;
      e = q.pop_front();
      eg = (e.v && e.id < N) ? (N'(1) << e.id) : '0;
      eh = e.v && e.id == N;
      bad = (proc_grant !== eg) || (host_grant !== eh) || (master_valid !== e.v) ||
            (e.v && master_id !== ID_W'(e.id));
      n_chk++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s: grant=%b host=%b valid=%b id=%0d expected grant=%b host=%b valid=%b id=%0d",
                 e.tag, proc_grant, host_grant, master_valid, master_id, eg, eh, e.v, e.id);
      end
    end
  end

  task automatic drive(input logic [N-1:0] r, input bit h, input bit lk, input bit rot,
                       input int cycles, input string t);
    @(negedge clk);
    proc_req = r; host_req = h; bus_lock = lk; rotate_en = rot; tag = t;
    repeat (cycles) @(posedge clk);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    drive('0, 0, 0, 0, 3, "R1");
    @(negedge clk); rst = 1'b0; tag = "R1";
    @(posedge clk);
    drive(6'b000100, 0, 0, 0, 2, "R3");          // idle -> agent 2 directly
    drive(6'b000101, 0, 0, 0, 3, "R4");          // agent 0 asks, 2 keeps
    drive(6'b010001, 0, 0, 0, 4, "R5");          // 2 drops: gap, then 0
    drive(6'b010000, 0, 0, 0, 1, "R5");          // 0 drops: gap starts
    drive(6'b000000, 0, 0, 0, 3, "R5");          // pending 4 granted anyway
    drive(6'b000000, 0, 0, 0, 3, "R10");         // parked on 4
    drive(6'b101010, 0, 0, 0, 4, "R6");          // fixed: 1 wins
    drive(6'b111100, 0, 0, 1, 4, "R7");          // rotate from 1: 2
    drive(6'b111000, 0, 0, 1, 4, "R7");          // 3
    drive(6'b100001, 0, 0, 1, 4, "R7");          // from 4: 5
    drive(6'b010001, 0, 0, 1, 4, "R7");          // wrap: 0
    drive(6'b000011, 1, 0, 0, 4, "R8");          // host preempts 0
    drive(6'b000110, 1, 0, 0, 3, "R8");          // host keeps
    drive(6'b000110, 0, 0, 0, 4, "R6");          // host drops: 1
    drive(6'b000000, 1, 1, 0, 4, "R9");          // locked owner stays
    drive(6'b000000, 1, 0, 0, 4, "R8");          // unlock: host
    drive(6'b000100, 0, 1, 0, 3, "R9");          // host locked, keeps
    drive(6'b000100, 0, 0, 0, 4, "R5");          // to 2 with gap
    drive('0, 0, 0, 0, 2, "R1");
    @(negedge clk); rst = 1'b1; tag = "R1";
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    drive(6'b100000, 0, 0, 1, 3, "R7");          // rotation restarts at 0
    drive(6'b100001, 0, 0, 1, 1, "R7");
    drive(6'b000001, 0, 0, 1, 4, "R7");
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[5:0], lfsr[6] & lfsr[9], lfsr[7] & lfsr[8] & lfsr[11], lfsr[12], 1, "R2");
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule